// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block decides which of eight analog input channels each conversion uses. Software writes a control word through a parallel write port. The word holds a two-bit sequence mode, a three-bit channel address and a group of general configuration bits. Every conversion-start strobe then advances a three-bit mux select according to the active mode. In the mask-based mode, the write that follows the mode write is taken as an eight-bit channel-select mask.

Three sequencing modes are available: a fixed single channel, a programmable walk through the set bits of the mask, and a consecutive walk from channel 0 up to an addressed final channel. A fourth mode code lets software rewrite the configuration bits without disturbing a sequence that is running. The end of a conversion is taken to be the start strobe itself.

Top module: `adc_chan_sequencer`

## Requirements
- R1: After reset the block is in single-channel mode with address 0 and an all-zero mask. In this state mux_sel, cfg_out, mask_pending and empty_err are all 0, and a start strobe selects channel 0.
- R2: A control write with mode bits {wr_data[4],wr_data[3]} = 00 selects single-channel mode. Every start strobe then selects the channel in wr_data[2:0].
- R3: A control write with mode bits 01 raises mask_pending. The next write is stored as the channel mask from wr_data[7:0], bit i standing for channel i, and clears mask_pending.
- R4: In programmable mode the first start strobe after the mask write selects the lowest channel whose mask bit is set. Each later strobe selects the next higher set channel.
- R5: In programmable mode, a strobe that follows the highest set channel wraps to the lowest set channel.
- R6: A control write with mode bits 11 selects consecutive mode. The first strobe after it selects channel 0, each later strobe adds one up to the channel in wr_data[2:0] inclusive, and the strobe after that returns to channel 0.
- R7: A control write with mode bits 10 loads cfg_out from wr_data[8:5] and leaves the mode, the address, the mask and the sequence position unchanged. Every other control write also loads cfg_out.
- R8: mux_sel changes only on the clock edge that samples a start strobe and holds in every other cycle.
- R9: When a write and a start strobe arrive in the same cycle, the strobe uses the configuration that the write produces.
- R10: In programmable mode with an all-zero mask, a strobe selects channel 0 and sets empty_err. empty_err then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a control word or a mask |
| wr_data | input | 9 | Control word {cfg[3:0], mode[1:0], addr[2:0]} or mask in bits [7:0] |
| conv_start | input | 1 | Conversion-start strobe |
| mux_sel | output | 3 | Channel of the most recent conversion |
| cfg_out | output | 4 | Configuration bits from the last control write |
| mask_pending | output | 1 | The next write will load the mask |
| empty_err | output | 1 | Sticky flag: a strobe found an empty mask |

## Verification
Every result is due one clock edge after its stimulus. mux_sel, cfg_out, mask_pending and empty_err all come from registers that load on the edge that samples wr_en or conv_start. The bench drives inputs on the falling edge and samples a quarter period after the next rising edge, so each comparison sees exactly one edge's update. A bench model advances with the same single edge and is compared after every cycle, directed and random alike. This covers the cases where a write and a strobe share a cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_PROG   = 2'd1,
      MODE_CONSEC = 2'd2
   } seq_mode_e;

   // mode pair {seq, shdw} from the control word
   localparam logic [1:0] PAIR_SINGLE = 2'b00;
   localparam logic [1:0] PAIR_MASK   = 2'b01;
   localparam logic [1:0] PAIR_KEEP   = 2'b10;
   localparam logic [1:0] PAIR_CONSEC = 2'b11;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CFG_W  = 4,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int CTRL_W = CFG_W + 2 + CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              conv_start,
   output seq_mode_e         mode_eff,
   output logic [CH_W-1:0]   addr_eff,
   output logic [NUM_CH-1:0] mask_eff,
   output logic              restart_eff,
   output logic [NUM_CH-1:0] mask_q,
   output logic [CH_W-1:0]   addr_q,
   output logic              pending_q,
   output logic [CFG_W-1:0]  cfg_q
);
   localparam int PAIR_LSB = CH_W;
   localparam int CFG_LSB  = CH_W + 2;

   seq_mode_e        mode_q;
   logic             restart_q;
   logic             pend_n;
   logic [CFG_W-1:0] cfg_n;
   logic [1:0]       pair;

   assign pair = wr_data[PAIR_LSB +: 2];

   // effective state: registered state with this cycle's write applied
   always_comb begin
      mode_eff    = mode_q;
      addr_eff    = addr_q;
      mask_eff    = mask_q;
      restart_eff = restart_q;
      pend_n      = pending_q;
      cfg_n       = cfg_q;
      if (wr_en) begin
         if (pending_q) begin
            mask_eff    = wr_data[NUM_CH-1:0];
            pend_n      = 1'b0;
            restart_eff = 1'b1;
         end else begin
            cfg_n = wr_data[CFG_LSB +: CFG_W];
            case (pair)
               PAIR_SINGLE: begin
                  mode_eff    = MODE_SINGLE;
                  addr_eff    = wr_data[CH_W-1:0];
                  restart_eff = 1'b1;
               end
               PAIR_MASK: begin
                  mode_eff    = MODE_PROG;
                  addr_eff    = wr_data[CH_W-1:0];
                  pend_n      = 1'b1;
                  restart_eff = 1'b1;
               end
               PAIR_CONSEC: begin
                  mode_eff    = MODE_CONSEC;
                  addr_eff    = wr_data[CH_W-1:0];
                  restart_eff = 1'b1;
               end
               default: ; // keep-running code: sequence untouched
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_SINGLE;
         addr_q    <= '0;
         mask_q    <= '0;
         pending_q <= 1'b0;
         cfg_q     <= '0;
         restart_q <= 1'b1;
      end else begin
         mode_q    <= mode_eff;
         addr_q    <= addr_eff;
         mask_q    <= mask_eff;
         pending_q <= pend_n;
         cfg_q     <= cfg_n;
         restart_q <= restart_eff & ~conv_start;
      end
   end

   // R3: the write after a mask-mode write lands in the mask
   a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pending_q) |=> (!pending_q && mask_q == $past(wr_data[NUM_CH-1:0])));

   // R7: keep-running write leaves the sequence state alone
   a_r7_keep_state: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pending_q && wr_data[PAIR_LSB +: 2] == PAIR_KEEP)
      |=> (mode_q == $past(mode_q) && addr_q == $past(addr_q) && mask_q == $past(mask_q)));

   // R7: every control write refreshes the configuration bits
   a_r7_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pending_q) |=> (cfg_q == $past(wr_data[CFG_LSB +: CFG_W])));
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  seq_mode_e         mode,
   input  logic [CH_W-1:0]   addr,
   input  logic [NUM_CH-1:0] mask,
   input  logic              restart,
   input  logic [CH_W-1:0]   cur,
   output logic [CH_W-1:0]   nxt,
   output logic              empty
);
   logic [NUM_CH-1:0] above;

   // mask bits strictly above the current channel
   for (genvar g = 0; g < NUM_CH; g++) begin : g_above
      assign above[g] = mask[g] && (g > int'(cur));
   end

   function automatic logic [CH_W-1:0] low_idx(input logic [NUM_CH-1:0] v);
      logic [CH_W-1:0] r;
      r = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (v[i]) r = CH_W'(i);
      end
      return r;
   endfunction

   always_comb begin
      empty = 1'b0;
      nxt   = addr;
      case (mode)
         MODE_SINGLE: nxt = addr;
         MODE_CONSEC: nxt = (restart || cur >= addr) ? '0 : cur + 1'b1;
         MODE_PROG: begin
            if (mask == '0) begin
               nxt   = '0;
               empty = 1'b1;
            end else if (!restart && (above != '0)) begin
               nxt = low_idx(above);
            end else begin
               nxt = low_idx(mask);
            end
         end
         default: nxt = addr;
      endcase
   end
endmodule

// File: rtl/adc_chan_sequencer.sv
module adc_chan_sequencer
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CFG_W  = 4,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int CTRL_W = CFG_W + 2 + CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              conv_start,
   output logic [CH_W-1:0]   mux_sel,
   output logic [CFG_W-1:0]  cfg_out,
   output logic              mask_pending,
   output logic              empty_err
);
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (CTRL_W < NUM_CH) begin : g_bad_w
      $error("control word narrower than the channel mask");
   end
   if (CFG_W < 1) begin : g_bad_cfg
      $error("CFG_W must be at least 1");
   end

   seq_mode_e         mode_eff;
   logic [CH_W-1:0]   addr_eff, addr_q, nxt;
   logic [NUM_CH-1:0] mask_eff, mask_q;
   logic              restart_eff, empty;

   adc_seq_regs #(.NUM_CH(NUM_CH), .CFG_W(CFG_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .conv_start  (conv_start),
      .mode_eff    (mode_eff),
      .addr_eff    (addr_eff),
      .mask_eff    (mask_eff),
      .restart_eff (restart_eff),
      .mask_q      (mask_q),
      .addr_q      (addr_q),
      .pending_q   (mask_pending),
      .cfg_q       (cfg_out)
   );

   adc_seq_pick #(.NUM_CH(NUM_CH)) u_pick (
      .mode    (mode_eff),
      .addr    (addr_eff),
      .mask    (mask_eff),
      .restart (restart_eff),
      .cur     (mux_sel),
      .nxt     (nxt),
      .empty   (empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mux_sel   <= '0;
         empty_err <= 1'b0;
      end else if (conv_start) begin
         mux_sel   <= nxt;
         empty_err <= empty_err | empty;
      end
   end

   // R8: no strobe, no movement
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_start |=> $stable(mux_sel));

   // R2 and R9: single mode lands on the address in force after the write
   a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && mode_eff == MODE_SINGLE) |=> (mux_sel == $past(addr_eff)));

   // R4: programmable mode only visits channels present in the mask
   a_r4_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && mode_eff == MODE_PROG && mask_eff != '0) |=> mask_q[mux_sel]);

   // R6: consecutive mode never passes the final channel
   a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && mode_eff == MODE_CONSEC) |=> (mux_sel <= addr_q));

   // R10: empty mask gives channel 0 and flags it
   a_r10_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && mode_eff == MODE_PROG && mask_eff == '0) |=> (mux_sel == '0 && empty_err));

   // R10: the flag is sticky
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      empty_err |=> empty_err);
endmodule

// File: tb/adc_chan_sequencer_test.sv
module adc_chan_sequencer_test;
   localparam int PERIOD = 10;
   localparam int NCH    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       conv_start = 1'b0;
   logic [2:0] mux_sel;
   logic [3:0] cfg_out;
   logic       mask_pending;
   logic       empty_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model: 0 single, 1 programmable, 2 consecutive
   int       m_mode = 0;
   int       m_addr = 0;
   bit [7:0] m_mask = '0;
   bit       m_pend = 1'b0;
   int       m_cfg  = 0;
   int       m_sel  = 0;
   bit       m_rst  = 1'b1;
   bit       m_err  = 1'b0;

   always #(PERIOD / 2) clk = ~clk;

   adc_chan_sequencer uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .conv_start   (conv_start),
      .mux_sel      (mux_sel),
      .cfg_out      (cfg_out),
      .mask_pending (mask_pending),
      .empty_err    (empty_err)
   );

   function automatic logic [8:0] ctrl(input int cfg, input int pair, input int addr);
      return {4'(cfg), 2'(pair), 3'(addr)};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int prog_next(input bit [7:0] mask, input int cur, input bit rs);
      int first;
      first = -1;
      for (int i = 0; i < NCH; i++) if (mask[i] && first < 0) first = i;
      if (!rs) for (int i = cur + 1; i < NCH; i++) if (mask[i]) return i;
      return first;
   endfunction

   task automatic model(input bit w, input logic [8:0] d, input bit s);
      if (w) begin
         if (m_pend) begin
            m_mask = d[7:0];
            m_pend = 1'b0;
            m_rst  = 1'b1;
         end else begin
            m_cfg = int'(d[8:5]);
            case (d[4:3])
               2'b00: begin m_mode = 0; m_addr = int'(d[2:0]); m_rst = 1'b1; end
               2'b01: begin m_mode = 1; m_addr = int'(d[2:0]); m_pend = 1'b1; m_rst = 1'b1; end
               2'b11: begin m_mode = 2; m_addr = int'(d[2:0]); m_rst = 1'b1; end
               default: ;
            endcase
         end
      end
      if (s) begin
         if (m_mode == 0) m_sel = m_addr;
         else if (m_mode == 2) m_sel = (m_rst || m_sel >= m_addr) ? 0 : m_sel + 1;
         else if (m_mask == 0) begin m_sel = 0; m_err = 1'b1; end
         else m_sel = prog_next(m_mask, m_sel, m_rst);
         m_rst = 1'b0;
      end
   endtask

   // one cycle: drive at falling edge, sample a quarter period after rising edge
   task automatic step(input bit w, input logic [8:0] d, input bit s);
      wr_en = w; wr_data = d; conv_start = s;
      model(w, d, s);
      @(posedge clk);
      #(PERIOD / 4);
      check("R8 mux_sel model", int'(mux_sel), m_sel);
      check("R7 cfg_out model", int'(cfg_out), m_cfg);
      check("R3 mask_pending model", int'(mask_pending), int'(m_pend));
      check("R10 empty_err model", int'(empty_err), int'(m_err));
      @(negedge clk);
      wr_en = 1'b0; conv_start = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 mux_sel", int'(mux_sel), 0);
      check("R1 cfg_out", int'(cfg_out), 0);
      check("R1 mask_pending", int'(mask_pending), 0);
      check("R1 empty_err", int'(empty_err), 0);
      step(1'b0, '0, 1'b1);
      check("R1 strobe after reset", int'(mux_sel), 0);

      // R2 single channel
      step(1'b1, ctrl(5, 0, 6), 1'b0);
      check("R2 no move before strobe", int'(mux_sel), 0);
      step(1'b0, '0, 1'b1);
      check("R2 single ch", int'(mux_sel), 6);
      step(1'b0, '0, 1'b1);
      check("R2 single repeat", int'(mux_sel), 6);
      step(1'b0, '0, 1'b0);
      check("R8 hold idle", int'(mux_sel), 6);

      // R3 mask programming, R4 order, R5 wrap
      step(1'b1, ctrl(1, 1, 0), 1'b0);
      check("R3 pending set", int'(mask_pending), 1);
      step(1'b1, 9'b0_1010_0100, 1'b0);
      check("R3 pending cleared", int'(mask_pending), 0);
      step(1'b0, '0, 1'b1);
      check("R4 lowest first", int'(mux_sel), 2);
      step(1'b0, '0, 1'b1);
      check("R4 next higher", int'(mux_sel), 5);
      step(1'b0, '0, 1'b1);
      check("R4 highest", int'(mux_sel), 7);
      step(1'b0, '0, 1'b1);
      check("R5 wrap lowest", int'(mux_sel), 2);

      // R7 keep-running write
      step(1'b1, ctrl(10, 2, 1), 1'b0);
      check("R7 cfg updated", int'(cfg_out), 10);
      check("R7 sel untouched", int'(mux_sel), 2);
      step(1'b0, '0, 1'b1);
      check("R7 sequence continues", int'(mux_sel), 5);

      // R6 consecutive
      step(1'b1, ctrl(3, 3, 2), 1'b0);
      step(1'b0, '0, 1'b1);
      check("R6 starts at 0", int'(mux_sel), 0);
      step(1'b0, '0, 1'b1);
      check("R6 step", int'(mux_sel), 1);
      step(1'b0, '0, 1'b1);
      check("R6 final inclusive", int'(mux_sel), 2);
      step(1'b0, '0, 1'b1);
      check("R6 wrap to 0", int'(mux_sel), 0);

      // R9 write and strobe together
      step(1'b1, ctrl(3, 0, 3), 1'b1);
      check("R9 write applies first", int'(mux_sel), 3);
      step(1'b1, ctrl(0, 3, 5), 1'b1);
      check("R9 consec restart same cycle", int'(mux_sel), 0);

      // R10 empty mask
      step(1'b1, ctrl(0, 1, 4), 1'b0);
      step(1'b1, 9'h000, 1'b0);
      step(1'b0, '0, 1'b1);
      check("R10 channel 0", int'(mux_sel), 0);
      check("R10 flag set", int'(empty_err), 1);
      step(1'b1, ctrl(0, 0, 7), 1'b1);
      check("R10 flag sticky", int'(empty_err), 1);

      // random phase against the model
      for (int n = 0; n < 4000; n++) begin
         bit          w, s;
         logic [8:0]  d;
         w = ($urandom % 10) < 3;
         s = ($urandom % 10) < 6;
         d = 9'($urandom);
         if (m_pend && ($urandom % 8) == 0) d[7:0] = '0;
         step(w, d, s);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule